// File: doc/BRIEF.md
# Delta-Modulation Sample Player with Memory Fetch

This block plays a one-bit delta-encoded sample stream. A processor sets it up through five byte-wide registers. Together they give the bit rate and option flags, a start address and a sample length, and a command that starts or stops playback. A fifth register lets software write the 7-bit output level directly. The block then reads the sample one byte at a time through a memory-read request port. Each request carries a stall length of four cycles, which the processor side uses to hold the processor while the read runs. The output is a 7-bit level meant for an audio mixer, plus an interrupt line.

Each fetched byte waits in a one-byte buffer. When the current 8-bit output cycle ends, the byte moves into a shift register. A rate timer then plays it out least significant bit first, one bit per timer period. A 1 bit moves the level up by two and a 0 bit moves it down by two, with clamping at the ends of the range. When a sample ends, the block either restarts it (loop mode) or stops. If it stops, it can raise an interrupt, which stays set until the next command write.

Register offsets on `reg_addr`:

| Offset | Register | Bits written |
|---|---|---|
| 0 | command | bit 4 starts or stops playback; any write clears the interrupt |
| 1 | mode | bit 7 interrupt enable, bit 6 loop, bits 3..0 rate index |
| 2 | base | start address step |
| 3 | count | sample length step |
| 4 | level | bits 6..0 go straight to the output level |

Top module: `dmc_channel`

## Requirements
- R1: After reset, `level_o` is 0, `irq_o` is 0, `mem_req` is 0, `stall_len` is 0 and `status_o` is 0.
- R2: One sample bit plays every P clock cycles. P comes from mode bits 3..0 through the table 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54 (index 0 to 15, so index 15 is fastest).
- R3: A write to level (offset 4) sets `level_o` to `reg_wdata[6:0]` on the next cycle. It takes priority over a step that falls in the same cycle.
- R4: Bits play least significant bit first. A 1 adds 2 to the level unless the result would pass 127, and a 0 subtracts 2 unless the result would drop below 0. While no byte is loaded, the level holds.
- R5: A command write with bit 4 set, made while no bytes remain, loads the address 0xC000 + 64 × base. A memory request follows on the next cycle if the byte buffer is empty.
- R6: `stall_len` reads 4 whenever `mem_req` is high, and 0 otherwise.
- R7: Each acknowledged fetch fills the buffer and advances the address by one, wrapping from 0xFFFF to 0x8000. A pending request keeps its address until it is acknowledged.
- R8: A sample with loop off is exactly 16 × count + 1 bytes long. After that many fetches, requests stop and `status_o[4]` (bytes remain) falls to 0.
- R9: When the last byte of a sample is fetched with mode bit 7 set and bit 6 clear, `irq_o` rises and `status_o[7]` shows it. It stays set across cycles and across writes to other registers.
- R10: Any write to the command register clears `irq_o` on the next cycle.
- R11: With mode bit 6 set, the address and length reload when the sample ends. Fetching continues from the start address and no interrupt is raised.
- R12: A command write with bit 4 clear sets the remaining byte count to zero. On the next cycle, `status_o[4]` and `mem_req` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| status_o | output | 8 | Bit 7 interrupt flag, bit 4 bytes remain, others 0 |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 16 | Address of the requested byte |
| mem_ack | input | 1 | Read completed; `mem_data` is valid |
| mem_data | input | 8 | Fetched sample byte |
| stall_len | output | 3 | Processor stall cycles for the pending fetch |
| level_o | output | 7 | Output level |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters. That means the 60 Hz-region rate table, a 9-bit timer, 7-bit levels, a four-cycle stall and shifts of 6 and 4 for address and length. At the fastest rate a byte lasts 432 cycles. This puts the 64-byte walk from 0xFFC0 across the 0xFFFF-to-0x8000 wrap within reach, along with a 17-byte sample and the slowest 428-cycle bit period. The 7-bit level puts both clamps, at 0 and at 127, within reach of a single byte.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   typedef enum logic [2:0] {
      REG_CMD   = 3'd0,
      REG_MODE  = 3'd1,
      REG_BASE  = 3'd2,
      REG_COUNT = 3'd3,
      REG_LEVEL = 3'd4
   } dmc_reg_e;

   // Cycles per played bit, 60 Hz region
   function automatic logic [8:0] ntsc_period(input logic [3:0] idx);
      case (idx)
         4'd0:    ntsc_period = 9'd428;
         4'd1:    ntsc_period = 9'd380;
         4'd2:    ntsc_period = 9'd340;
         4'd3:    ntsc_period = 9'd320;
         4'd4:    ntsc_period = 9'd286;
         4'd5:    ntsc_period = 9'd254;
         4'd6:    ntsc_period = 9'd226;
         4'd7:    ntsc_period = 9'd214;
         4'd8:    ntsc_period = 9'd190;
         4'd9:    ntsc_period = 9'd160;
         4'd10:   ntsc_period = 9'd142;
         4'd11:   ntsc_period = 9'd128;
         4'd12:   ntsc_period = 9'd106;
         4'd13:   ntsc_period = 9'd84;
         4'd14:   ntsc_period = 9'd72;
         default: ntsc_period = 9'd54;
      endcase
   endfunction

   // Cycles per played bit, 50 Hz region
   function automatic logic [8:0] pal_period(input logic [3:0] idx);
      case (idx)
         4'd0:    pal_period = 9'd398;
         4'd1:    pal_period = 9'd354;
         4'd2:    pal_period = 9'd316;
         4'd3:    pal_period = 9'd298;
         4'd4:    pal_period = 9'd276;
         4'd5:    pal_period = 9'd236;
         4'd6:    pal_period = 9'd210;
         4'd7:    pal_period = 9'd198;
         4'd8:    pal_period = 9'd176;
         4'd9:    pal_period = 9'd148;
         4'd10:   pal_period = 9'd132;
         4'd11:   pal_period = 9'd118;
         4'd12:   pal_period = 9'd98;
         4'd13:   pal_period = 9'd78;
         4'd14:   pal_period = 9'd66;
         default: pal_period = 9'd50;
      endcase
   endfunction

endpackage

// File: rtl/dmc_rate_timer.sv
module dmc_rate_timer #(
   parameter int TIMER_W = 9,
   parameter int REGION  = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] rate_idx,
   output logic       tick
);
   logic [TIMER_W-1:0] period;
   logic [TIMER_W-1:0] cnt;

   generate
      if (REGION == 0) begin : g_ntsc
         assign period = TIMER_W'(dmc_pkg::ntsc_period(rate_idx));
      end else begin : g_pal
         assign period = TIMER_W'(dmc_pkg::pal_period(rate_idx));
      end
   endgenerate

   assign tick = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= period - TIMER_W'(1);
      else           cnt <= cnt - TIMER_W'(1);
   end
endmodule

// File: rtl/dmc_fetch_unit.sv
module dmc_fetch_unit #(
   parameter int LEN_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [15:0]      start_addr,
   input  logic [LEN_W-1:0] sample_len,
   input  logic             loop_en,
   input  logic             irq_en,
   input  logic             cmd_wr,
   input  logic             cmd_enable,
   input  logic             consume,
   input  logic             mem_ack,
   input  logic [7:0]       mem_data,
   output logic             mem_req,
   output logic [15:0]      mem_addr,
   output logic             buf_valid,
   output logic [7:0]       buf_data,
   output logic             active,
   output logic             irq
);
   logic [15:0]      addr_q;
   logic [LEN_W-1:0] left_q;
   logic             take;
   logic             last;

   assign active   = (left_q != '0);
   assign mem_req  = !buf_valid && active;
   assign mem_addr = addr_q;
   assign take     = mem_req && mem_ack;
   assign last     = (left_q == LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= 16'hC000;
         left_q    <= '0;
         buf_valid <= 1'b0;
         buf_data  <= '0;
         irq       <= 1'b0;
      end else begin
         if (consume) buf_valid <= 1'b0;
         if (take) begin
            buf_valid <= 1'b1;
            buf_data  <= mem_data;
            addr_q    <= (addr_q == 16'hFFFF) ? 16'h8000 : addr_q + 16'd1;
            if (last) begin
               if (loop_en) begin
                  addr_q <= start_addr;
                  left_q <= sample_len;
               end else begin
                  left_q <= '0;
                  if (irq_en) irq <= 1'b1;
               end
            end else begin
               left_q <= left_q - LEN_W'(1);
            end
         end
         if (cmd_wr) begin
            irq <= 1'b0;
            if (!cmd_enable) begin
               left_q <= '0;
            end else if (!active) begin
               addr_q <= start_addr;
               left_q <= sample_len;
            end
         end
      end
   end
endmodule

// File: rtl/dmc_output_unit.sv
module dmc_output_unit #(
   parameter int LEVEL_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               buf_valid,
   input  logic [7:0]         buf_data,
   input  logic               level_wr,
   input  logic [LEVEL_W-1:0] level_val,
   output logic               consume,
   output logic [LEVEL_W-1:0] level
);
   localparam int unsigned LVL_MAX = (1 << LEVEL_W) - 1;
   localparam logic [LEVEL_W-1:0] UP_LIMIT = LEVEL_W'(LVL_MAX - 2);
   localparam logic [LEVEL_W-1:0] STEP     = LEVEL_W'(2);

   logic [7:0] shreg;
   logic [3:0] bits_left;
   logic       silent;
   logic       wrap;

   assign wrap    = (bits_left == 4'd1);
   assign consume = tick && wrap && buf_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         bits_left <= 4'd8;
         silent    <= 1'b1;
         level     <= '0;
      end else begin
         if (tick) begin
            if (!silent) begin
               if (shreg[0]) begin
                  if (level <= UP_LIMIT) level <= level + STEP;
               end else begin
                  if (level >= STEP) level <= level - STEP;
               end
            end
            shreg <= shreg >> 1;
            if (wrap) begin
               bits_left <= 4'd8;
               if (buf_valid) begin
                  shreg  <= buf_data;
                  silent <= 1'b0;
               end else begin
                  silent <= 1'b1;
               end
            end else begin
               bits_left <= bits_left - 4'd1;
            end
         end
         if (level_wr) level <= level_val;
      end
   end
endmodule

// File: rtl/dmc_channel.sv
module dmc_channel #(
   parameter int LEVEL_W    = 7,
   parameter int TIMER_W    = 9,
   parameter int REGION     = 0,
   parameter int STALL_CYC  = 4,
   parameter int ADDR_SHIFT = 6,
   parameter int LEN_SHIFT  = 4,
   parameter int STALL_W    = $clog2(STALL_CYC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [2:0]         reg_addr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         status_o,
   output logic               mem_req,
   output logic [15:0]        mem_addr,
   input  logic               mem_ack,
   input  logic [7:0]         mem_data,
   output logic [STALL_W-1:0] stall_len,
   output logic [LEVEL_W-1:0] level_o,
   output logic               irq_o
);
   import dmc_pkg::*;

   localparam int LEN_W = 9 + LEN_SHIFT;

   generate
      if (LEVEL_W < 3) begin : g_bad_level
         $error("dmc_channel: LEVEL_W must be at least 3");
      end
      if (TIMER_W < 9) begin : g_bad_timer
         $error("dmc_channel: TIMER_W must hold the longest period");
      end
      if (STALL_CYC < 1) begin : g_bad_stall
         $error("dmc_channel: STALL_CYC must be positive");
      end
      if (ADDR_SHIFT > 6) begin : g_bad_shift
         $error("dmc_channel: ADDR_SHIFT above 6 leaves the address space");
      end
   endgenerate

   logic       wr_cmd, wr_mode, wr_base, wr_count, wr_level;
   logic [3:0] rate_idx;
   logic       irq_en, loop_en;
   logic [7:0] base_val, count_val;
   logic [15:0]      start_addr;
   logic [LEN_W-1:0] sample_len;
   logic       tick, consume, buf_valid, active;
   logic [7:0] buf_data;

   assign wr_cmd   = reg_wr && (reg_addr == REG_CMD);
   assign wr_mode  = reg_wr && (reg_addr == REG_MODE);
   assign wr_base  = reg_wr && (reg_addr == REG_BASE);
   assign wr_count = reg_wr && (reg_addr == REG_COUNT);
   assign wr_level = reg_wr && (reg_addr == REG_LEVEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_idx  <= '0;
         irq_en    <= 1'b0;
         loop_en   <= 1'b0;
         base_val  <= '0;
         count_val <= '0;
      end else begin
         if (wr_mode) begin
            irq_en   <= reg_wdata[7];
            loop_en  <= reg_wdata[6];
            rate_idx <= reg_wdata[3:0];
         end
         if (wr_base)  base_val  <= reg_wdata;
         if (wr_count) count_val <= reg_wdata;
      end
   end

   assign start_addr = 16'hC000 + (16'(base_val) << ADDR_SHIFT);
   assign sample_len = (LEN_W'(count_val) << LEN_SHIFT) + LEN_W'(1);

   dmc_rate_timer #(.TIMER_W(TIMER_W), .REGION(REGION)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_idx (rate_idx),
      .tick     (tick)
   );

   dmc_fetch_unit #(.LEN_W(LEN_W)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_addr (start_addr),
      .sample_len (sample_len),
      .loop_en    (loop_en),
      .irq_en     (irq_en),
      .cmd_wr     (wr_cmd),
      .cmd_enable (reg_wdata[4]),
      .consume    (consume),
      .mem_ack    (mem_ack),
      .mem_data   (mem_data),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .buf_valid  (buf_valid),
      .buf_data   (buf_data),
      .active     (active),
      .irq        (irq_o)
   );

   dmc_output_unit #(.LEVEL_W(LEVEL_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .buf_valid (buf_valid),
      .buf_data  (buf_data),
      .level_wr  (wr_level),
      .level_val (reg_wdata[LEVEL_W-1:0]),
      .consume   (consume),
      .level     (level_o)
   );

   assign stall_len = mem_req ? STALL_W'(STALL_CYC) : '0;
   assign status_o  = {irq_o, 2'b00, active, 4'b0000};
endmodule

// File: rtl/dmc_channel_chk.sv
module dmc_channel_chk #(
   parameter int LEVEL_W   = 7,
   parameter int STALL_CYC = 4,
   parameter int STALL_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [2:0]         reg_addr,
   input logic [7:0]         reg_wdata,
   input logic [7:0]         status_o,
   input logic               mem_req,
   input logic [15:0]        mem_addr,
   input logic               mem_ack,
   input logic [STALL_W-1:0] stall_len,
   input logic [LEVEL_W-1:0] level_o,
   input logic               irq_o,
   input logic [15:0]        start_addr
);
   logic cmd_w, lvl_w;
   assign cmd_w = reg_wr && (reg_addr == 3'd0);
   assign lvl_w = reg_wr && (reg_addr == 3'd4);

   // R3
   a_r3_level_load: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_w |=> level_o == $past(reg_wdata[LEVEL_W-1:0]));

   // R4
   a_r4_step_size: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(lvl_w) |-> (level_o == $past(level_o)) ||
                        (int'(level_o) == int'($past(level_o)) + 2) ||
                        (int'(level_o) + 2 == int'($past(level_o))));

   // R5
   a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_w && reg_wdata[4] && !status_o[4] |=> status_o[4] && mem_addr == $past(start_addr));

   // R6
   a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ack |-> stall_len == STALL_W'(STALL_CYC));

   // R7
   a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack && !cmd_w |=> mem_req && $stable(mem_addr));

   // R9
   a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && !cmd_w |=> irq_o && status_o[7]);

   // R10
   a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_w |=> !irq_o);

   // R12
   a_r12_stop: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_w && !reg_wdata[4] |=> !status_o[4] && !mem_req);
endmodule

bind dmc_channel dmc_channel_chk #(
   .LEVEL_W(LEVEL_W), .STALL_CYC(STALL_CYC), .STALL_W(STALL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .status_o   (status_o),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_ack    (mem_ack),
   .stall_len  (stall_len),
   .level_o    (level_o),
   .irq_o      (irq_o),
   .start_addr (start_addr)
);

// File: tb/tb_dmc_channel.sv
module tb_dmc_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  status_o;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [7:0]  mem_data = '0;
   logic [2:0]  stall_len;
   logic [6:0]  level_o;
   logic        irq_o;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   int fetch_count = 0;
   int stall_bad = 0;
   logic [7:0]  mem_byte = 8'h00;
   logic [15:0] addr_log [256];
   bit          rec = 1'b0;
   int          nchg = 0;
   int          chg_t [16];
   logic [6:0]  lvl_prev = '0;

   // rate, byte, start level, expected final level
   localparam logic [25:0] VEC [7] = '{
      {4'd15, 8'hFF, 7'd10,  7'd26},
      {4'd15, 8'h00, 7'd10,  7'd0},
      {4'd15, 8'h0F, 7'd60,  7'd60},
      {4'd14, 8'hAA, 7'd126, 7'd126},
      {4'd15, 8'hFF, 7'd120, 7'd126},
      {4'd0,  8'h01, 7'd1,   7'd1},
      {4'd8,  8'h80, 7'd0,   7'd2}
   };
   localparam int PER [16] = '{428, 380, 340, 320, 286, 254, 226, 214,
                               190, 160, 142, 128, 106, 84, 72, 54};

   dmc_channel dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .status_o(status_o), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
      .stall_len(stall_len), .level_o(level_o), .irq_o(irq_o)
   );

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // memory model: one-cycle read latency
   always @(negedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         mem_ack  <= 1'b1;
         mem_data <= mem_byte;
         addr_log[fetch_count % 256] <= mem_addr;
         if (stall_len != 3'd4) stall_bad = stall_bad + 1;
         fetch_count = fetch_count + 1;
      end
   end

   always @(negedge clk) begin
      if (rec && level_o != lvl_prev && nchg < 16) begin
         chg_t[nchg] = cyc;
         nchg = nchg + 1;
      end
      lvl_prev <= level_o;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_vec(input logic [25:0] v);
      wr(3'd1, {4'b0000, v[25:22]});
      wr(3'd3, 8'd0);
      wr(3'd2, 8'd0);
      mem_byte = v[21:14];
      wr(3'd4, {1'b0, v[13:7]});
      wr(3'd0, 8'h10);
      idle(20 * PER[v[25:22]] + 500);
      chk("R4 final level", int'(level_o), int'(v[6:0]));
   endtask

   task automatic measure(input logic [3:0] idx);
      wr(3'd4, 8'd0);
      wr(3'd1, {4'b0000, idx});
      wr(3'd3, 8'd0);
      mem_byte = 8'hFF;
      idle(2);
      nchg = 0;
      rec = 1'b1;
      wr(3'd0, 8'h10);
      idle(20 * PER[idx] + 500);
      rec = 1'b0;
      chk("R2 change count", nchg, 8);
      chk("R2 bit period", chg_t[3] - chg_t[2], PER[idx]);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      int base;
      logic [6:0] held;
      idle(3);
      // R1 reset state
      chk("R1 level", int'(level_o), 0);
      chk("R1 irq", int'(irq_o), 0);
      chk("R1 request", int'(mem_req), 0);
      chk("R1 status", int'(status_o), 0);
      rst_n = 1'b1;
      idle(2);
      chk("R1 stall idle", int'(stall_len), 0);

      // R3 direct load, bit 7 ignored
      wr(3'd4, 8'hD5);
      chk("R3 level load", int'(level_o), 8'h55);

      // R4 vector walk
      for (int i = 0; i < 7; i++) run_vec(VEC[i]);
      held = level_o;
      idle(2000);
      chk("R4 silent hold", int'(level_o), int'(held));

      // R2 bit periods
      measure(4'd15);
      measure(4'd0);

      // R5 R8 R7: 17-byte sample from base 2
      wr(3'd1, 8'h0F);
      wr(3'd2, 8'd2);
      wr(3'd3, 8'd1);
      base = fetch_count;
      wr(3'd0, 8'h10);
      chk("R5 request next cycle", int'(mem_req), 1);
      chk("R5 start address", int'(mem_addr), 16'hC080);
      while (status_o[4]) @(negedge clk);
      idle(1000);
      chk("R8 fetch total", fetch_count - base, 17);
      chk("R7 first address", int'(addr_log[base % 256]), 16'hC080);
      chk("R7 last address", int'(addr_log[(base + 16) % 256]), 16'hC090);
      chk("R8 request stopped", int'(mem_req), 0);
      chk("R9 no irq when disabled", int'(irq_o), 0);

      // R9 R10 interrupt
      wr(3'd1, 8'h8F);
      wr(3'd3, 8'd0);
      wr(3'd0, 8'h10);
      while (status_o[4]) @(negedge clk);
      idle(2);
      chk("R9 irq raised", int'(irq_o), 1);
      chk("R9 status bit 7", int'(status_o[7]), 1);
      idle(100);
      wr(3'd4, 8'd40);
      chk("R9 irq held", int'(irq_o), 1);
      wr(3'd0, 8'h00);
      chk("R10 irq cleared", int'(irq_o), 0);
      chk("R10 status bit 7", int'(status_o[7]), 0);

      // R11 loop then R12 stop
      wr(3'd1, 8'h4F);
      wr(3'd2, 8'd0);
      base = fetch_count;
      wr(3'd0, 8'h10);
      while (fetch_count - base < 4) @(negedge clk);
      idle(2);
      chk("R11 reload addr 1", int'(addr_log[(base + 1) % 256]), 16'hC000);
      chk("R11 reload addr 3", int'(addr_log[(base + 3) % 256]), 16'hC000);
      chk("R11 still active", int'(status_o[4]), 1);
      chk("R11 no irq", int'(irq_o), 0);
      wr(3'd0, 8'h00);
      chk("R12 bytes cleared", int'(status_o[4]), 0);
      chk("R12 request dropped", int'(mem_req), 0);
      base = fetch_count;
      idle(1000);
      chk("R12 no further fetch", fetch_count - base, 0);

      // R7 wrap from 0xFFFF to 0x8000
      wr(3'd1, 8'h0F);
      wr(3'd2, 8'hFF);
      wr(3'd3, 8'hFF);
      base = fetch_count;
      wr(3'd0, 8'h10);
      while (fetch_count - base < 66) @(negedge clk);
      idle(2);
      chk("R7 wrap first", int'(addr_log[base % 256]), 16'hFFC0);
      chk("R7 wrap top", int'(addr_log[(base + 63) % 256]), 16'hFFFF);
      chk("R7 wrap to 8000", int'(addr_log[(base + 64) % 256]), 16'h8000);
      chk("R7 after wrap", int'(addr_log[(base + 65) % 256]), 16'h8001);
      wr(3'd0, 8'h00);
      chk("R12 stop long sample", int'(status_o[4]), 0);

      chk("R6 stall length at fetch", stall_bad, 0);
      chk("R6 stall idle", int'(stall_len), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule